// File: doc/BRIEF.md
# Serial LED Sink Driver Front End

This block is the digital control path of a sixteen-channel LED sink driver. A host moves data into a chain of stages one bit per rising edge of a serial clock. A storage stage, controlled by a level, either follows the chain or freezes the word it holds. A blanking input forces every channel off without disturbing the stored word. The outermost stage of the chain is driven out on a serial output, so several such blocks can be cascaded on one data line.

The whole block runs on one system clock `clk`. The serial clock, data, load level and blanking input are sampled on each rising edge of `clk`. A serial-clock rising edge is detected as a low sample followed by a high sample. The storage stage is an enabled register that takes the chain's new value in the same cycle as the shift. The channel vector and serial output are registered. Every output therefore reflects the inputs sampled at the `clk` edge that updates it. The current sinks themselves are represented by the on/off vector `chan_on`.

Top module: `led_sink_front`

## Requirements
- R1: After synchronous reset, the chain and the held word are zero, so `chan_on` is all zero and `ser_out` is 0; a serial-clock rise is not recognised until a low sample of `ser_clk` has been taken after reset.
- R2: A serial-clock rise (sample 0 at one `clk` edge, 1 at the next) moves `ser_in` into stage 0, and every stage i takes the old content of stage i-1.
- R3: When `ser_clk` stays low, stays high or falls, the chain, `chan_on` (with unchanged control inputs) and `ser_out` keep their values.
- R4: Stage i, and so channel i when visible, holds the bit shifted i rises earlier; channel 0 is the newest bit.
- R5: While `load` is 1 the storage stage is transparent: `chan_on` shows the chain including a shift taken at the same `clk` edge.
- R6: While `load` is 0 the held word does not change, whatever is shifted in.
- R7: While `blank` is 1 every bit of `chan_on` is 0; the held word is kept and reappears when `blank` returns to 0.
- R8: A held 1 turns its channel on (bit = 1) and a 0 turns it off; `ser_out` always equals stage 15, the bit shifted 15 rises earlier, so a cascaded block sees data 16 rises later.
- R9: `ser_out` changes only at a `clk` edge at which a serial-clock rise is recognised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, all state updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock, sampled by `clk` |
| ser_in | input | 1 | Serial data, taken on a serial-clock rise |
| load | input | 1 | 1: storage transparent, 0: storage holds |
| blank | input | 1 | 1: all channels forced off |
| chan_on | output | 16 | Channel on/off vector, bit i = channel i |
| ser_out | output | 1 | Last chain stage, for cascading |

## Verification
The checker watches on every cycle that blanking clears the channel vector. It also checks that a frozen store keeps the channels steady, that the serial output stays still without a recognised rise, and that with a transparent store the serial output tracks channel 15. On shift cycles it checks that channel 0 takes the new bit and the other channels move up by one. Whether a word survives a long blanked interval, and whether a word loaded behind a frozen store appears only once the store opens, can only be seen in the bench's directed sequences. The same holds for the effect of reset on edge detection and for agreement with a reference model under random control patterns.

// File: rtl/led_sink_pkg.sv
package led_sink_pkg;
  localparam int unsigned DEF_CHANNELS = 16;

  // Control inputs as seen in one clk cycle
  typedef struct packed {
    logic rise;
    logic data;
    logic load;
    logic blank;
  } ctl_t;

  function automatic logic rise_of(input logic now_v, input logic prev_v);
    return now_v & ~prev_v;
  endfunction
endpackage

// File: rtl/lsf_edge.sv
module lsf_edge (
  input  logic clk,
  input  logic rst,
  input  logic ser_clk,
  output logic rise
);
  import led_sink_pkg::*;
  logic prev_q;

  // prev_q resets high so a level already high at reset is not a rise
  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= ser_clk;
  end

  assign rise = ~rst & rise_of(ser_clk, prev_q);
endmodule

// File: rtl/lsf_shift.sv
module lsf_shift #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rise,
  input  logic         din,
  output logic [N-1:0] chain_next,
  output logic         sdo
);
  localparam int unsigned LAST = N - 1;
  logic [N-1:0] chain_q;

  always_comb begin
    chain_next = chain_q;
    if (rise) begin
      chain_next[0] = din;
      for (int i = 1; i < N; i++) chain_next[i] = chain_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      sdo     <= 1'b0;
    end else begin
      chain_q <= chain_next;
      if (rise) sdo <= chain_next[LAST];
    end
  end
endmodule

// File: rtl/lsf_store.sv
module lsf_store #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         blank,
  input  logic [N-1:0] chain_next,
  output logic [N-1:0] chan_on
);
  logic [N-1:0] held_q;
  logic [N-1:0] held_d;

  assign held_d = load ? chain_next : held_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q  <= '0;
      chan_on <= '0;
    end else begin
      held_q <= held_d;
      for (int i = 0; i < N; i++) chan_on[i] <= held_d[i] & ~blank;
    end
  end
endmodule

// File: rtl/led_sink_front.sv
module led_sink_front #(
  parameter int unsigned N_CH = led_sink_pkg::DEF_CHANNELS
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ser_clk,
  input  logic            ser_in,
  input  logic            load,
  input  logic            blank,
  output logic [N_CH-1:0] chan_on,
  output logic            ser_out
);
  import led_sink_pkg::*;
  ctl_t            ctl;
  logic            rise_w;
  logic [N_CH-1:0] chain_next_w;

  lsf_edge u_edge (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .rise(rise_w)
  );

  assign ctl = '{rise: rise_w, data: ser_in, load: load, blank: blank};

  lsf_shift #(.N(N_CH)) u_shift (
    .clk(clk), .rst(rst), .rise(ctl.rise), .din(ctl.data),
    .chain_next(chain_next_w), .sdo(ser_out)
  );

  lsf_store #(.N(N_CH)) u_store (
    .clk(clk), .rst(rst), .load(ctl.load), .blank(ctl.blank),
    .chain_next(chain_next_w), .chan_on(chan_on)
  );
endmodule

// File: rtl/led_sink_front_chk.sv
module led_sink_front_chk #(
  parameter int unsigned N_CH = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            ser_clk,
  input logic            ser_in,
  input logic            load,
  input logic            blank,
  input logic [N_CH-1:0] chan_on,
  input logic            ser_out
);
  a_r7_blank_clears: assert property (@(posedge clk) disable iff (rst)
    blank |=> chan_on == '0);

  a_r6_store_frozen: assert property (@(posedge clk) disable iff (rst)
    (!load && !blank && !$past(blank)) |=> $stable(chan_on));

  a_r9_sdo_quiet: assert property (@(posedge clk) disable iff (rst)
    (!ser_clk || $past(ser_clk)) |=> $stable(ser_out));

  a_r8_sdo_last: assert property (@(posedge clk) disable iff (rst)
    (load && !blank) |=> ser_out == chan_on[N_CH-1]);

  a_r5_new_bit: assert property (@(posedge clk) disable iff (rst)
    (load && !blank && ser_clk && !$past(ser_clk) && !$past(rst))
      |=> chan_on[0] == $past(ser_in));

  a_r4_move_up: assert property (@(posedge clk) disable iff (rst)
    (load && !blank && $past(load) && !$past(blank) && ser_clk &&
     !$past(ser_clk) && !$past(rst))
      |=> chan_on[N_CH-1:1] == $past(chan_on[N_CH-2:0]));
endmodule

bind led_sink_front led_sink_front_chk #(.N_CH(N_CH)) u_chk (
  .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_in(ser_in), .load(load),
  .blank(blank), .chan_on(chan_on), .ser_out(ser_out)
);

// File: tb/tb_led_sink_front.sv
module tb_led_sink_front;
  localparam int N = 16;
  logic clk = 1'b0;
  logic rst, ser_clk, ser_in, load, blank;
  logic [N-1:0] chan_on;
  logic ser_out;
  int total = 0, bad = 0;

  // reference state from the requirements
  logic [N-1:0] m_chain, m_held;
  logic m_prev, m_sdo;

  always #2 clk = ~clk;

  led_sink_front #(.N_CH(N)) dut (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_in(ser_in),
    .load(load), .blank(blank), .chan_on(chan_on), .ser_out(ser_out)
  );

  function automatic logic [N-1:0] exp_chan();
    return blank ? '0 : m_held;
  endfunction

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_chain = '0; m_held = '0; m_prev = 1'b1; m_sdo = 1'b0;
  endtask

  // one clk cycle: drive, edge, update model, sample after the edge
  task automatic step(input logic sc, input logic sd, input logic ld, input logic bl,
                      input bit do_chk);
    @(negedge clk);
    ser_clk = sc; ser_in = sd; load = ld; blank = bl;
    @(posedge clk);
    if (sc && !m_prev) begin
      m_chain = {m_chain[N-2:0], sd};
      m_sdo = m_chain[N-1];
    end
    m_prev = sc;
    if (ld) m_held = m_chain;
    #1;
    if (do_chk) begin
      chk("R2 R4 R5 R6 R7 R8 chan_on", chan_on, exp_chan());
      chk("R8 R9 ser_out", {{(N-1){1'b0}}, ser_out}, {{(N-1){1'b0}}, m_sdo});
    end
  endtask

  task automatic shift_word(input logic [N-1:0] w, input logic ld, input logic bl);
    for (int i = N - 1; i >= 0; i--) begin
      step(1'b0, w[i], ld, bl, 1'b0);
      step(1'b1, w[i], ld, bl, 1'b0);
    end
  endtask

  initial begin
    #800000;
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    rst = 1'b1; ser_clk = 1'b1; ser_in = 1'b0; load = 1'b1; blank = 1'b0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk("R1 reset chan_on", chan_on, '0);
    chk("R1 reset ser_out", {{(N-1){1'b0}}, ser_out}, '0);
    // ser_clk high from reset: no rise
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R1 no rise after reset", chan_on, '0);

    shift_word(16'hA5C3, 1'b1, 1'b0);
    chk("R4 word order", chan_on, 16'hA5C3);
    chk("R8 ser_out is stage 15", {{(N-1){1'b0}}, ser_out}, 16'h0001);

    // R3: hold high, then fall, with data toggling
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R3 no shift without rise", chan_on, 16'hA5C3);

    // R2 single rise
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R2 one shift", chan_on, 16'h4B86);
    chk("R9 ser_out after rise", {{(N-1){1'b0}}, ser_out}, '0);

    // R6 frozen store while a new word moves in
    shift_word(16'h3C0F, 1'b0, 1'b0);
    chk("R6 held while load low", chan_on, 16'h4B86);
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R5 opens to chain", chan_on, 16'h3C0F);

    // R7 blanking keeps stored word
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R7 blanked", chan_on, '0);
    shift_word(16'hFFFF, 1'b0, 1'b1);
    chk("R7 still blanked", chan_on, '0);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R7 word returns", chan_on, 16'h3C0F);

    // R8 cascade delay: a lone 1 reaches ser_out after 16 rises
    shift_word(16'h0000, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    for (int k = 1; k < N; k++) begin
      chk("R8 ser_out before stage 15", {{(N-1){1'b0}}, ser_out}, '0);
      step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
      step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    end
    chk("R8 ser_out at stage 15", {{(N-1){1'b0}}, ser_out}, 16'h0001);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] r;
      r = 4'($urandom);
      step(r[0], r[1], r[2] | r[3], ($urandom % 5) == 0, 1'b1);
    end

    // reset mid-run
    @(negedge clk); rst = 1'b1; ser_clk = 1'b0;
    @(posedge clk); model_reset();
    @(negedge clk); rst = 1'b0; load = 1'b1; blank = 1'b0;
    #1;
    chk("R1 reset again", chan_on, '0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule